// File: doc/BRIEF.md
# 16-bit Instruction Word Decoder

This block is the combinational decode stage of a single-cycle datapath for a 16-bit, four-class instruction set. It takes one instruction word and splits it into its class, subtype and 5-bit instruction number. From these it produces the three register-file selects, the raw immediate field of the word's class, a 5-bit ALU operation code, and the four datapath strobes: condition-code update, data-memory read, data-memory write and register write.

Three of the 32 instruction numbers have no meaning. The block marks them with an illegal flag and holds every strobe low for them, so an undefined word changes no architectural state. The register file, ALU, memories and program-counter logic are outside this block. Each of them takes what it needs from the outputs and ignores the selects it has no use for.

Top module: `insn_decode16`

## Requirements
- R1: Class is bits 15:14 (0=A, 1=B, 2=C, 3=D). Subtype is bits 13:11. The instruction number is bits 15:11.
- R2: The A select is always bits 7:5, the B select bits 4:2 and the W select bits 10:8, whatever the class.
- R3: The immediate output is zero-extended to 11 bits. Class A gives 0, class B gives bits 4:0, class C gives bits 7:0 and class D gives bits 10:0.
- R4: Numbers 6, 17 and 19 raise the illegal flag. For them all four strobes are 0 and the ALU code is 31 (no operation). All other numbers keep the flag low.
- R5: Condition update is 1 exactly for numbers 0 to 5, 9, 11, 12, 20 and 22. These are the flag-setting operations.
- R6: The compares, numbers 5 and 20, set condition update and never assert register write or memory write.
- R7: Memory read is 1 only for the loads, numbers 8 and 23. Memory write is 1 only for the store, number 10. The two are never 1 together, and a store never writes a register.
- R8: Register write is 1 exactly for numbers 0 to 4, 8, 9, 11 to 16, 18 and 21 to 23. It is never set for class D.
- R9: The ALU code uses ADD=0, SUB=1, AND=2, OR=3, XOR=4, LSH=5, ASH=6, ROT=7, PASSB=8, MERGEHI=9, PASSA=10 and NOP=31. The mapping is:
  - numbers 0, 8, 9, 10, 21 and 23 give ADD;
  - numbers 1, 5, 20 and 22 give SUB;
  - numbers 2 and 11 give AND;
  - numbers 3 and 12 give OR;
  - number 4 gives XOR;
  - numbers 13, 14 and 15 give LSH, ASH and ROT;
  - number 16 gives PASSB;
  - number 18 gives MERGEHI;
  - number 7 gives PASSA;
  - class D and the illegal numbers give NOP.
- R10: Add-immediate with flags (number 9) gives condition update 1, register write 1 and memory read 0. The unconditional branch (number 24) gives condition update 0, register write 0 and memory read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| cls_o | output | 2 | Instruction class |
| subtype_o | output | 3 | Subtype within the class |
| opnum_o | output | 5 | Instruction number |
| asel_o | output | 3 | Register-file A read select |
| bsel_o | output | 3 | Register-file B read select |
| wsel_o | output | 3 | Register-file write select |
| imm_o | output | 11 | Raw immediate of the class, zero-extended |
| alu_op_o | output | 5 | ALU operation code |
| cond_upd_o | output | 1 | Update condition codes |
| mem_rd_o | output | 1 | Data-memory read |
| mem_wr_o | output | 1 | Data-memory write |
| reg_wr_o | output | 1 | Register-file write |
| illegal_o | output | 1 | Instruction number is undefined |

## Verification
The hardest case to reach is an undefined number whose operand bits look like a real instruction. Such a word must still leave every strobe low, even though its class neighbours do write registers or memory. The stimulus sweeps all 32 instruction numbers with the same busy operand pattern in bits 10:0. Each undefined number therefore sits between defined neighbours that use the same W, A and B fields. Separate patterns with alternating and inverted operand bits check that the selects and the immediate field do not depend on the class.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int INSN_W = 16;
  localparam int NUM_W  = 5;
  localparam int SEL_W  = 3;
  localparam int IMM_W  = 11;
  localparam int ALU_W  = 5;

  typedef enum logic [1:0] {CLS_A = 2'd0, CLS_B = 2'd1, CLS_C = 2'd2, CLS_D = 2'd3} cls_e;

  localparam logic [ALU_W-1:0] ALU_ADD     = 5'd0;
  localparam logic [ALU_W-1:0] ALU_SUB     = 5'd1;
  localparam logic [ALU_W-1:0] ALU_AND     = 5'd2;
  localparam logic [ALU_W-1:0] ALU_OR      = 5'd3;
  localparam logic [ALU_W-1:0] ALU_XOR     = 5'd4;
  localparam logic [ALU_W-1:0] ALU_LSH     = 5'd5;
  localparam logic [ALU_W-1:0] ALU_ASH     = 5'd6;
  localparam logic [ALU_W-1:0] ALU_ROT     = 5'd7;
  localparam logic [ALU_W-1:0] ALU_PASSB   = 5'd8;
  localparam logic [ALU_W-1:0] ALU_MERGEHI = 5'd9;
  localparam logic [ALU_W-1:0] ALU_PASSA   = 5'd10;
  localparam logic [ALU_W-1:0] ALU_NOP     = 5'd31;

  typedef struct packed {
    logic [ALU_W-1:0] alu;
    logic             cond;
    logic             mrd;
    logic             mwr;
    logic             rwr;
    logic             ill;
  } ctrl_t;

  // Raw immediate of a class, zero-extended to IMM_W bits.
  function automatic logic [IMM_W-1:0] imm_of(input cls_e c, input logic [INSN_W-1:0] w);
    logic [IMM_W-1:0] r;
    unique case (c)
      CLS_A:   r = '0;
      CLS_B:   r = {{(IMM_W-5){1'b0}}, w[4:0]};
      CLS_C:   r = {{(IMM_W-8){1'b0}}, w[7:0]};
      default: r = w[IMM_W-1:0];
    endcase
    return r;
  endfunction

  // One control entry: ALU code and strobes {cond, mrd, mwr, rwr}.
  function automatic ctrl_t mk(input logic [ALU_W-1:0] a, input logic [3:0] s);
    ctrl_t c;
    c.alu  = a;
    c.cond = s[3];
    c.mrd  = s[2];
    c.mwr  = s[1];
    c.rwr  = s[0];
    c.ill  = 1'b0;
    return c;
  endfunction
endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
(
  input  logic [INSN_W-1:0] word_i,
  output cls_e              cls_o,
  output logic [2:0]        sub_o,
  output logic [NUM_W-1:0]  num_o,
  output logic [SEL_W-1:0]  asel_o,
  output logic [SEL_W-1:0]  bsel_o,
  output logic [SEL_W-1:0]  wsel_o,
  output logic [IMM_W-1:0]  imm_o
);
  assign cls_o  = cls_e'(word_i[15:14]);
  assign sub_o  = word_i[13:11];
  assign num_o  = word_i[15:11];
  assign wsel_o = word_i[10:8];
  assign asel_o = word_i[7:5];
  assign bsel_o = word_i[4:2];
  assign imm_o  = imm_of(cls_o, word_i);
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import idec_pkg::*;
(
  input  logic [NUM_W-1:0] num_i,
  output ctrl_t            ctrl_o
);
  // Strobe nibble order is {cond, mrd, mwr, rwr}.
  always_comb begin
    unique case (num_i)
      5'd0:  ctrl_o = mk(ALU_ADD,     4'b1001);
      5'd1:  ctrl_o = mk(ALU_SUB,     4'b1001);
      5'd2:  ctrl_o = mk(ALU_AND,     4'b1001);
      5'd3:  ctrl_o = mk(ALU_OR,      4'b1001);
      5'd4:  ctrl_o = mk(ALU_XOR,     4'b1001);
      5'd5:  ctrl_o = mk(ALU_SUB,     4'b1000);
      5'd7:  ctrl_o = mk(ALU_PASSA,   4'b0000);
      5'd8:  ctrl_o = mk(ALU_ADD,     4'b0101);
      5'd9:  ctrl_o = mk(ALU_ADD,     4'b1001);
      5'd10: ctrl_o = mk(ALU_ADD,     4'b0010);
      5'd11: ctrl_o = mk(ALU_AND,     4'b1001);
      5'd12: ctrl_o = mk(ALU_OR,      4'b1001);
      5'd13: ctrl_o = mk(ALU_LSH,     4'b0001);
      5'd14: ctrl_o = mk(ALU_ASH,     4'b0001);
      5'd15: ctrl_o = mk(ALU_ROT,     4'b0001);
      5'd16: ctrl_o = mk(ALU_PASSB,   4'b0001);
      5'd18: ctrl_o = mk(ALU_MERGEHI, 4'b0001);
      5'd20: ctrl_o = mk(ALU_SUB,     4'b1000);
      5'd21: ctrl_o = mk(ALU_ADD,     4'b0001);
      5'd22: ctrl_o = mk(ALU_SUB,     4'b1001);
      5'd23: ctrl_o = mk(ALU_ADD,     4'b0101);
      5'd6, 5'd17, 5'd19: begin
        ctrl_o     = mk(ALU_NOP, 4'b0000);
        ctrl_o.ill = 1'b1;
      end
      default: ctrl_o = mk(ALU_NOP, 4'b0000);  // class D: branches and halt
    endcase
  end

  // An undefined number must leave every strobe low (R4).
  always_comb begin
    if (!$isunknown(num_i)) begin
      p_illegal_quiet_r4: assert (!ctrl_o.ill || !(ctrl_o.cond | ctrl_o.mrd | ctrl_o.mwr | ctrl_o.rwr))
        else $error("illegal number %0d asserts a strobe", num_i);
      p_mem_exclusive_r7: assert (!(ctrl_o.mrd && ctrl_o.mwr))
        else $error("read and write together for %0d", num_i);
    end
  end
endmodule

// File: rtl/insn_decode16.sv
module insn_decode16
  import idec_pkg::*;
(
  input  logic [15:0] instr_i,
  output logic [1:0]  cls_o,
  output logic [2:0]  subtype_o,
  output logic [4:0]  opnum_o,
  output logic [2:0]  asel_o,
  output logic [2:0]  bsel_o,
  output logic [2:0]  wsel_o,
  output logic [10:0] imm_o,
  output logic [4:0]  alu_op_o,
  output logic        cond_upd_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic        reg_wr_o,
  output logic        illegal_o
);
  cls_e             cls_w;
  logic [NUM_W-1:0] num_w;
  ctrl_t            ctrl_w;

  idec_fields u_fields (
    .word_i (instr_i),
    .cls_o  (cls_w),
    .sub_o  (subtype_o),
    .num_o  (num_w),
    .asel_o (asel_o),
    .bsel_o (bsel_o),
    .wsel_o (wsel_o),
    .imm_o  (imm_o)
  );

  idec_ctrl u_ctrl (
    .num_i  (num_w),
    .ctrl_o (ctrl_w)
  );

  assign cls_o      = cls_w;
  assign opnum_o    = num_w;
  assign alu_op_o   = ctrl_w.alu;
  assign cond_upd_o = ctrl_w.cond;
  assign mem_rd_o   = ctrl_w.mrd;
  assign mem_wr_o   = ctrl_w.mwr;
  assign reg_wr_o   = ctrl_w.rwr;
  assign illegal_o  = ctrl_w.ill;

  // Cross checks between the field splitter and the control table.
  always_comb begin
    if (!$isunknown(instr_i)) begin
      p_dclass_no_write_r8: assert (cls_w != CLS_D || (!reg_wr_o && !mem_wr_o && !cond_upd_o))
        else $error("class D word %h writes state", instr_i);
      p_store_no_regwr_r7: assert (!mem_wr_o || !reg_wr_o)
        else $error("store also writes a register, word %h", instr_i);
      p_aclass_no_imm_r3: assert (cls_w != CLS_A || imm_o == '0)
        else $error("class A word %h shows an immediate", instr_i);
      p_compare_no_write_r6: assert (!(cond_upd_o && alu_op_o == ALU_SUB && !reg_wr_o) || !mem_wr_o)
        else $error("compare writes memory, word %h", instr_i);
    end
  end
endmodule

// File: tb/insn_decode16_tb_top.sv
module insn_decode16_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] instr;
  logic [1:0]  cls;
  logic [2:0]  sub, asel, bsel, wsel;
  logic [4:0]  num, alu;
  logic [10:0] imm;
  logic        cond, mrd, mwr, rwr, ill;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  insn_decode16 dut_i (
    .instr_i(instr), .cls_o(cls), .subtype_o(sub), .opnum_o(num),
    .asel_o(asel), .bsel_o(bsel), .wsel_o(wsel), .imm_o(imm),
    .alu_op_o(alu), .cond_upd_o(cond), .mem_rd_o(mrd), .mem_wr_o(mwr),
    .reg_wr_o(rwr), .illegal_o(ill)
  );

  // Expected control sets, one bit per instruction number.
  localparam logic [31:0] COND_SET = 32'h0050_1A3F;
  localparam logic [31:0] RWR_SET  = 32'h00E5_FB1F;
  localparam logic [31:0] MRD_SET  = 32'h0080_0100;
  localparam logic [31:0] MWR_SET  = 32'h0000_0400;
  localparam logic [31:0] ILL_SET  = 32'h000A_0040;

  function automatic logic [4:0] exp_alu(input int k);
    if (k >= 24 || k == 6 || k == 17 || k == 19) return 5'd31;
    if (k == 1 || k == 5 || k == 20 || k == 22) return 5'd1;
    if (k == 2 || k == 11) return 5'd2;
    if (k == 3 || k == 12) return 5'd3;
    if (k == 4) return 5'd4;
    if (k >= 13 && k <= 15) return 5'(k - 8);
    if (k == 16) return 5'd8;
    if (k == 18) return 5'd9;
    if (k == 7) return 5'd10;
    return 5'd0;
  endfunction

  function automatic logic [10:0] exp_imm(input logic [15:0] w);
    case (w[15:14])
      2'd0: return 11'd0;
      2'd1: return {6'd0, w[4:0]};
      2'd2: return {3'd0, w[7:0]};
      default: return w[10:0];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (word %h)", tag, act, exp, instr);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    instr = 16'h0000;
    #1;
    chk("R1 reset num", 32'(num), 0);
    chk("R9 reset alu", 32'(alu), 0);
    chk("R8 reset rwr", 32'(rwr), 1);
    chk("R4 reset ill", 32'(ill), 0);
  endtask

  task automatic t_fields(input logic [15:0] w);
    apply(w);
    chk("R1 class", 32'(cls), 32'(w[15:14]));
    chk("R1 subtype", 32'(sub), 32'(w[13:11]));
    chk("R1 number", 32'(num), 32'(w[15:11]));
    chk("R2 asel", 32'(asel), 32'(w[7:5]));
    chk("R2 bsel", 32'(bsel), 32'(w[4:2]));
    chk("R2 wsel", 32'(wsel), 32'(w[10:8]));
    chk("R3 imm", 32'(imm), 32'(exp_imm(w)));
  endtask

  task automatic t_sweep(input logic [10:0] ops);
    for (int k = 0; k < 32; k++) begin
      apply({5'(k), ops});
      chk("R4 illegal", 32'(ill), 32'(ILL_SET[k]));
      chk("R5 cond", 32'(cond), 32'(COND_SET[k]));
      chk("R7 memrd", 32'(mrd), 32'(MRD_SET[k]));
      chk("R7 memwr", 32'(mwr), 32'(MWR_SET[k]));
      chk("R8 regwr", 32'(rwr), 32'(RWR_SET[k]));
      chk("R9 alu", 32'(alu), 32'(exp_alu(k)));
      if (k == 5 || k == 20) begin
        chk("R6 cmp cond", 32'(cond), 1);
        chk("R6 cmp regwr", 32'(rwr | mwr), 0);
      end
    end
  endtask

  task automatic t_named;
    apply(16'h4921);  // number 9
    chk("R10 addi cond", 32'(cond), 1);
    chk("R10 addi regwr", 32'(rwr), 1);
    chk("R10 addi memrd", 32'(mrd), 0);
    apply(16'hC7EE);  // number 24
    chk("R10 b cond", 32'(cond), 0);
    chk("R10 b regwr", 32'(rwr), 0);
    chk("R10 b memrd", 32'(mrd), 0);
  endtask

  initial begin
    instr = 16'h0000;
    fork
      begin
        t_reset();
        rst = 1'b0;
        t_fields(16'h1234);
        t_fields(16'h5A5B);
        t_fields(16'hA5C3);
        t_fields(16'hFFFF);
        t_fields(16'h3ABD);
        t_sweep(11'h5A5);
        t_sweep(11'h2FF);
        t_named();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule